// File: doc/BRIEF.md
# Credit-Returning Stream Receive Thread

This block is the receiving end of one thread in a credit-based streaming fabric. A sender holds credits equal to the number of free entries the receiver advertises. It spends one credit for each data phase it sends. A data phase carries a data word and start-of-packet, end-of-packet and teardown flags. The receiver keeps the phases in a local buffer and hands them in order to a local consumer through a valid/ready pair. It gives back one credit, as a single-cycle pulse, for every entry that leaves the buffer or is thrown away.

Software sees a read-only capabilities word. This word gives the local datapath width as a code and the number of buffer entries. Software also controls a real-time word with run, pause and flush bits. A stopped or flushing thread still takes every arriving phase and still returns its credit, so the sender's handshake never stalls. Teardown is never written by software. It arrives in-band with the data. The thread marks it, drains, returns every credit and then stops itself. An idle bit shows that a stopped thread has no data left and no credit still owed.

Top module: `dst_thread`

## Requirements
- R1: `caps` reads as: bits 28:24 hold the width code log2(DATA_W/32), so 0 means 4 bytes and 1 means 8 bytes; bits 7:0 hold DEPTH; every other bit is 0. The default configuration reads 32'h0100_0008.
- R2: After a synchronous reset, `rt_status` reads 32'h0000_0002: run, teardown, pause and flush are clear and idle is set. Also after reset, `out_valid`, `credit_ret` and `ovf_err` are low.
- R3: While running, not paused and not flushing, stored phases reach the consumer in arrival order. The data and the sop, eop and teardown flags arrive unchanged.
- R4: Each phase the consumer takes (`out_valid` and `out_ready` high at a clock edge) returns exactly one credit. A credit is one cycle of `credit_ret` high, starting no earlier than the cycle after the edge.
- R5: When the run bit (`rt_status[31]`) is clear, an arriving phase is thrown away and never reaches the consumer, but one credit is still returned for it.
- R6: Clearing the run bit discards every held entry and returns one credit for each one. A later restart delivers none of the discarded entries.
- R7: While flush (`rt_status[28]`) is set, held and arriving phases are thrown away, nothing reaches the consumer, and one credit is returned for each.
- R8: While pause (`rt_status[29]`) is set, `out_valid` stays low and stored entries are kept. After pause clears, they are delivered in order.
- R9: A phase that arrives with its teardown flag while the thread is running sets the teardown bit (`rt_status[30]`) from the next cycle on. The teardown bit has no software write path.
- R10: Once teardown is set, the buffer is empty and every credit has been returned, the thread clears its run and teardown bits by itself.
- R11: Idle (`rt_status[1]`) is high exactly when the run bit is clear, the buffer is empty and no credit return is pending. It is never high while the thread is running.
- R12: A phase that arrives while running with DEPTH entries already held is dropped and returns no credit. `ovf_err` goes high for one cycle, in the cycle after the arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming data phase present (sender spent a credit) |
| in_data | input | DATA_W | Incoming data word |
| in_sop | input | 1 | Start-of-packet flag |
| in_eop | input | 1 | End-of-packet flag |
| in_tdown | input | 1 | In-band teardown flag |
| credit_ret | output | 1 | One credit returned to the sender per high cycle |
| out_valid | output | 1 | Phase offered to the consumer |
| out_ready | input | 1 | Consumer accepts the offered phase |
| out_data | output | DATA_W | Offered data word |
| out_sop | output | 1 | Offered start-of-packet flag |
| out_eop | output | 1 | Offered end-of-packet flag |
| out_tdown | output | 1 | Offered teardown flag |
| sw_we | input | 1 | Software write strobe for run, pause and flush |
| sw_run | input | 1 | Run value to write |
| sw_pause | input | 1 | Pause value to write |
| sw_flush | input | 1 | Flush value to write |
| rt_status | output | 32 | Real-time word: 31 run, 30 teardown, 29 pause, 28 flush, 1 idle |
| caps | output | 32 | Capabilities word: 28:24 width code, 7:0 entry count |
| ovf_err | output | 1 | Phase arrived with the buffer full |

## Verification
The properties assume a sender that keeps to its credits. Under that assumption an arriving phase is refused only through the overflow path, and pending credits never exceed the buffer depth. They also assume that no teardown phase arrives in the same cycle as a software write. The stimulus changes every input just after the falling edge and waits for credits to drain between phases of the test. It sends more phases than the buffer holds only once, on purpose, to provoke an overflow. It never writes run, pause or flush in the same cycle as a teardown phase.

// File: rtl/dst_thread_pkg.sv
package dst_thread_pkg;

    // Bit positions in the real-time word; software decodes these.
    localparam int RT_RUN   = 31;
    localparam int RT_TDOWN = 30;
    localparam int RT_PAUSE = 29;
    localparam int RT_FLUSH = 28;
    localparam int RT_IDLE  = 1;

    typedef struct packed {
        logic run;
        logic tdown;
        logic pause;
        logic flush;
    } rt_state_t;

    // Width code: 0 = 32 bits, 1 = 64 bits, ... 5 = 1024 bits.
    function automatic logic [4:0] width_code(input int data_w);
        return 5'($clog2(data_w / 32));
    endfunction

    function automatic logic [31:0] caps_word(input int data_w, input int depth);
        logic [31:0] w;
        w        = '0;
        w[28:24] = width_code(data_w);
        w[7:0]   = 8'(depth);
        return w;
    endfunction

    function automatic logic [31:0] rt_word(input rt_state_t s, input logic idle);
        logic [31:0] w;
        w           = '0;
        w[RT_RUN]   = s.run;
        w[RT_TDOWN] = s.tdown;
        w[RT_PAUSE] = s.pause;
        w[RT_FLUSH] = s.flush;
        w[RT_IDLE]  = idle;
        return w;
    endfunction

endpackage

// File: rtl/dst_fifo.sv
module dst_fifo #(
    parameter int W     = 67,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign count = cnt;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
            if (pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/dst_credit_ret.sv
module dst_credit_ret #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] add,
    output logic          credit_ret,
    output logic          none_pending
);
    logic [PW-1:0] pend;

    assign credit_ret   = (pend != '0);
    assign none_pending = (pend == '0);

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend + add - PW'(credit_ret);
    end
endmodule

// File: rtl/dst_rt_ctrl.sv
module dst_rt_ctrl
    import dst_thread_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sw_we,
    input  logic      sw_run,
    input  logic      sw_pause,
    input  logic      sw_flush,
    input  logic      tdown_seen,
    input  logic      drained,
    output rt_state_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (sw_we) begin
            st.run   <= sw_run;
            st.pause <= sw_pause;
            st.flush <= sw_flush;
            st.tdown <= sw_run ? (st.tdown | tdown_seen) : 1'b0;
        end else if (st.tdown && drained) begin
            st.run   <= 1'b0;
            st.tdown <= 1'b0;
        end else if (tdown_seen) begin
            st.tdown <= 1'b1;
        end
    end
endmodule

// File: rtl/dst_thread.sv
module dst_thread
    import dst_thread_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_tdown,
    output logic              credit_ret,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_tdown,
    input  logic              sw_we,
    input  logic              sw_run,
    input  logic              sw_pause,
    input  logic              sw_flush,
    output logic [31:0]       rt_status,
    output logic [31:0]       caps,
    output logic              ovf_err
);
    localparam int EW = DATA_W + 3;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = $clog2(2 * DEPTH + 3);

    rt_state_t     st;
    logic          fifo_empty, fifo_full, none_pending;
    logic [CW-1:0] fifo_cnt;
    logic [EW-1:0] head;
    logic          live, store_ok, push, drop_in, pop_flush, pop_any;
    logic          tdown_seen, drained;
    logic [PW-1:0] credit_add;

    // A live thread runs and is not flushing: it keeps what arrives.
    assign live      = st.run && !st.flush;
    assign store_ok  = in_valid && live;
    assign push      = store_ok && !fifo_full;
    assign drop_in   = in_valid && !live;
    assign out_valid = live && !st.pause && !fifo_empty;
    assign pop_flush = st.run && st.flush && !fifo_empty;
    assign pop_any   = (out_valid && out_ready) || pop_flush;

    assign credit_add = PW'(drop_in) + PW'(pop_any)
                      + (st.run ? PW'(0) : PW'(fifo_cnt));

    assign tdown_seen = in_valid && in_tdown && st.run;
    assign drained    = fifo_empty && none_pending && !in_valid;

    dst_fifo #(.W(EW), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .clear (!st.run),
        .push  (push),
        .wdata ({in_tdown, in_eop, in_sop, in_data}),
        .pop   (pop_any),
        .rdata (head),
        .count (fifo_cnt),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    dst_credit_ret #(.PW(PW)) u_cred (
        .clk          (clk),
        .rst          (rst),
        .add          (credit_add),
        .credit_ret   (credit_ret),
        .none_pending (none_pending)
    );

    dst_rt_ctrl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .sw_we      (sw_we),
        .sw_run     (sw_run),
        .sw_pause   (sw_pause),
        .sw_flush   (sw_flush),
        .tdown_seen (tdown_seen),
        .drained    (drained),
        .st         (st)
    );

    assign {out_tdown, out_eop, out_sop, out_data} = head;

    assign rt_status = rt_word(st, !st.run && fifo_empty && none_pending);
    assign caps      = caps_word(DATA_W, DEPTH);

    always_ff @(posedge clk) begin
        if (rst) ovf_err <= 1'b0;
        else     ovf_err <= store_ok && fifo_full;
    end
endmodule

// File: rtl/dst_thread_chk.sv
module dst_thread_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_tdown,
    input logic        out_valid,
    input logic        out_ready,
    input logic        credit_ret,
    input logic        sw_we,
    input logic [31:0] rt_status
);
    p_idle_only_stopped_r11: assert property (@(posedge clk) disable iff (rst)
        rt_status[1] |-> !rt_status[31]);

    p_paused_holds_r8: assert property (@(posedge clk) disable iff (rst)
        rt_status[29] |-> !out_valid);

    p_flush_no_deliver_r7: assert property (@(posedge clk) disable iff (rst)
        rt_status[28] |-> !out_valid);

    p_stopped_no_deliver_r5: assert property (@(posedge clk) disable iff (rst)
        !rt_status[31] |-> !out_valid);

    p_drop_credits_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rt_status[31]) |=> credit_ret);

    p_take_credits_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> credit_ret);

    p_tdown_marks_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_tdown && rt_status[31] && !sw_we) |=> rt_status[30]);

    p_self_stop_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(rt_status[31]) && !$past(sw_we)) |-> $past(rt_status[30]));
endmodule

bind dst_thread dst_thread_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_tdown   (in_tdown),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .credit_ret (credit_ret),
    .sw_we      (sw_we),
    .rt_status  (rt_status)
);

// File: tb/tb_dst_thread.sv
module tb_dst_thread;
    localparam int DATA_W = 64;
    localparam int DEPTH  = 8;
    localparam int EW     = DATA_W + 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_tdown = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_ready = 1'b0;
    logic              sw_we = 1'b0, sw_run = 1'b0, sw_pause = 1'b0, sw_flush = 1'b0;
    logic              credit_ret, out_valid, out_sop, out_eop, out_tdown, ovf_err;
    logic [DATA_W-1:0] out_data;
    logic [31:0]       rt_status, caps;

    int n_cmp = 0, n_bad = 0, n_deliv = 0, n_cred = 0;
    logic [EW-1:0] sb_q [$];
    bit finished = 0;

    always #2.5 clk = ~clk;

    dst_thread #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: samples 1 ns after each falling edge; inputs change at the edge itself.
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (credit_ret) n_cred++;
            if (out_valid && out_ready) begin
                n_deliv++;
                if (sb_q.size() == 0) begin
                    check(0, "R3 unexpected delivery", {out_tdown, out_eop, out_sop, out_data[60:0]}, 0);
                end else begin
                    logic [EW-1:0] e;
                    e = sb_q.pop_front();
                    check({out_tdown, out_eop, out_sop, out_data} == e, "R3 phase order/content",
                          out_data, e[DATA_W-1:0]);
                end
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [DATA_W-1:0] d, input bit s, input bit e, input bit t, input bit expect_out);
        @(negedge clk);
        in_valid = 1; in_data = d; in_sop = s; in_eop = e; in_tdown = t;
        if (expect_out) sb_q.push_back({t, e, s, d});
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0; in_tdown = 0;
    endtask

    task automatic sw_write(input bit r, input bit p, input bit f);
        @(negedge clk);
        sw_we = 1; sw_run = r; sw_pause = p; sw_flush = f;
        @(negedge clk);
        sw_we = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int c0, d0;
        cycles(3);
        @(negedge clk); rst = 0;
        #1;
        check(rt_status == 32'h2, "R2 status after reset", rt_status, 32'h2);
        check(!out_valid && !credit_ret && !ovf_err, "R2 outputs after reset",
              {out_valid, credit_ret, ovf_err}, 0);
        check(caps == 32'h0100_0008, "R1 caps word", caps, 32'h0100_0008);

        // Basic forwarding
        sw_write(1, 0, 0);
        #1;
        check(rt_status == 32'h8000_0000, "R11 idle clear while running", rt_status, 32'h8000_0000);
        out_ready = 1;
        c0 = n_cred;
        send(64'h1111_0001, 1, 0, 0, 1);
        send(64'h2222_0002, 0, 0, 0, 1);
        send(64'h3333_0003, 0, 1, 0, 1);
        cycles(8);
        check(sb_q.size() == 0, "R3 all delivered", sb_q.size(), 0);
        check(n_cred - c0 == 3, "R4 one credit per consumed phase", n_cred - c0, 3);

        // Pause
        sw_write(1, 1, 0);
        c0 = n_cred; d0 = n_deliv;
        for (int i = 0; i < 4; i++) send(64'hAB00 + i, i == 0, i == 3, 0, 1);
        cycles(6);
        check(n_deliv == d0 && !out_valid, "R8 nothing delivered while paused", n_deliv - d0, 0);
        check(n_cred == c0, "R8 no credit while paused", n_cred - c0, 0);
        sw_write(1, 0, 0);
        cycles(10);
        check(n_deliv - d0 == 4 && sb_q.size() == 0, "R8 resumed in order", n_deliv - d0, 4);
        check(n_cred - c0 == 4, "R4 credits after resume", n_cred - c0, 4);

        // Overflow
        out_ready = 0;
        c0 = n_cred;
        for (int i = 0; i < DEPTH; i++) send(64'hC000 + i, i == 0, 0, 0, 1);
        send(64'hDEAD, 0, 1, 0, 0);
        #1;
        check(ovf_err == 1'b1, "R12 overflow flagged", ovf_err, 1);
        cycles(1); #1;
        check(ovf_err == 1'b0, "R12 overflow single cycle", ovf_err, 0);
        check(n_cred == c0, "R12 no credit for dropped phase", n_cred - c0, 0);
        out_ready = 1;
        cycles(20);
        check(sb_q.size() == 0 && n_cred - c0 == DEPTH, "R12 only held entries delivered",
              n_cred - c0, DEPTH);

        // Stop with held entries, then arrivals while stopped
        out_ready = 0;
        for (int i = 0; i < 3; i++) send(64'hE000 + i, 0, 0, 0, 0);
        c0 = n_cred; d0 = n_deliv;
        sw_write(0, 0, 0);
        cycles(6);
        check(n_cred - c0 == 3, "R6 credits for discarded entries", n_cred - c0, 3);
        #1;
        check(rt_status == 32'h2, "R11 idle when stopped and drained", rt_status, 32'h2);
        c0 = n_cred;
        out_ready = 1;
        send(64'hF001, 1, 0, 0, 0);
        send(64'hF002, 0, 1, 0, 0);
        cycles(4);
        check(n_cred - c0 == 2, "R5 credit per dropped arrival", n_cred - c0, 2);
        check(n_deliv == d0, "R5 nothing delivered while stopped", n_deliv - d0, 0);
        sw_write(1, 0, 0);
        cycles(4);
        check(n_deliv == d0 && !out_valid, "R6 discarded entries stay gone", n_deliv - d0, 0);

        // Flush
        out_ready = 0;
        send(64'h5001, 1, 0, 0, 0);
        send(64'h5002, 0, 0, 0, 0);
        c0 = n_cred; d0 = n_deliv;
        sw_write(1, 0, 1);
        out_ready = 1;
        send(64'h5003, 0, 0, 0, 0);
        send(64'h5004, 0, 1, 0, 0);
        cycles(6);
        check(n_cred - c0 == 4, "R7 credits while flushing", n_cred - c0, 4);
        check(n_deliv == d0, "R7 nothing delivered while flushing", n_deliv - d0, 0);
        sw_write(1, 0, 0);

        // Teardown
        out_ready = 0;
        send(64'h7001, 1, 0, 0, 1);
        send(64'h7002, 0, 0, 0, 1);
        send(64'h7003, 0, 1, 1, 1);
        #1;
        check(rt_status[30] && rt_status[31], "R9 teardown marked, still running",
              rt_status[31:28], 4'hC);
        c0 = n_cred;
        out_ready = 1;
        cycles(12);
        check(sb_q.size() == 0 && n_cred - c0 == 3, "R10 drained before stop", n_cred - c0, 3);
        #1;
        check(rt_status == 32'h2, "R10 run and teardown cleared", rt_status, 32'h2);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule